// File: doc/BRIEF.md
# Shared interrupt source conditioner

This block takes a parameterised group of external interrupt lines (32 by default) and turns each one into a pending bit. Each line has its own sense settings. A polarity bit chooses the active level or the active edge. A trigger bit chooses between level sensing and a latched edge. A dual-edge bit makes an edge-mode line latch on both transitions. Software can force a line's latched edge state on or off through an injection word. Software enables lines through separate set and clear words, and it can read back the enable mask and the pending lines.

Each line carries a routing word. The routing word can send the line to one of several CPU interrupt pins. A pin output is asserted when at least one line routed to it is both pending and enabled. Alongside the pins the block gives a vector number, which is the lowest active pin number plus one. The register bus is a plain 32-bit word-addressed port. Writes take effect on the clock edge, and reads are combinational from the address.

Word addresses: 0 polarity, 1 trigger, 2 dual-edge, 3 edge injection, 4 mask clear, 5 mask set, 6 mask read, 7 pending read, 8+i routing word of line i. Any other address reads as 0.

Top module: `irq_src_conditioner`

## Requirements
- R1: After reset, the following are all 0: the polarity, trigger, dual-edge, mask and routing registers, every latched edge state, the `cpu_pin` outputs and `cpu_vec`.
- R2: For a line whose trigger bit is 0, the pending bit follows the input in the same cycle. With polarity 1 the line is pending while the input is high. With polarity 0 it is pending while the input is low. The pending word at address 7 has bit i for line i.
- R3: For a line whose trigger bit is 1 and dual-edge bit is 0, a rising input latches the line pending when polarity is 1. A falling input latches it when polarity is 0. The latch is visible in the cycle after the transition is sampled, and the line then stays pending when the input returns.
- R4: For a line whose trigger bit is 1 and dual-edge bit is 1, both a rising and a falling transition latch the line pending.
- R5: A write to address 3 acts on the line numbered in bits [4:0]. Bits 30:5 are ignored. If bit 31 is 1, the write sets that line's latched edge state. If bit 31 is 0, the write clears it.
- R6: Writing to address 5 enables each line whose data bit is 1. Writing to address 4 disables each line whose data bit is 1. Data bits of 0 leave the mask unchanged. In the mask word at address 6, a 1 means the line is enabled.
- R7: A routing word routes the line when bit 31 is 1, and bits [5:0] give the pin number. The word reads back with those bits and zeros elsewhere. Pin p is high one cycle after any line is pending, enabled and routed to p.
- R8: `cpu_vec` is the lowest active pin number plus one, or 0 when no pin is active. It changes in the same cycle as `cpu_pin`.
- R9: Writes to the mask-read address (6) and the pending-read address (7) change nothing.
- R10: When a line's hardware edge and a software clear of the same line fall in the same cycle, the line ends up pending.
- R11: A line whose routing bit 31 is 0, or whose pin number is not below NUM_PINS, drives no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_LINES | Interrupt lines, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_pin | output | NUM_PINS | Registered CPU interrupt pins |
| cpu_vec | output | VEC_W | Registered vector number, lowest active pin plus one |

## Verification
The assertions assume three things about the inputs:
- The interrupt lines are already synchronous to the clock, so a transition is seen in exactly one sampled cycle.
- The bus performs at most one write per cycle.
- An injection write names a single line, so its set and clear strobes never meet on one line.

The stimulus keeps within these assumptions. It changes the lines and the bus only just after the falling clock edge. It never issues more than one write per cycle, and the injection index always comes from the low five data bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_W    = 32;
  localparam int PIN_FLD_W = 6;
  localparam int CTL_BIT   = 31;

  localparam int OFS_POL      = 0;
  localparam int OFS_TRIG     = 1;
  localparam int OFS_DUAL     = 2;
  localparam int OFS_INJECT   = 3;
  localparam int OFS_MASK_CLR = 4;
  localparam int OFS_MASK_SET = 5;
  localparam int OFS_MASK_RD  = 6;
  localparam int OFS_PEND_RD  = 7;
  localparam int OFS_ROUTE    = 8;

  typedef struct packed {
    logic                 en;
    logic [PIN_FLD_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic inj_set_i,
  input  logic inj_clr_i,
  output logic pend_o
);
  logic prev_q, edge_q, edge_d, edge_en;
  logic rise, fall, hit;

  always_comb begin
    rise = irq_i & ~prev_q;
    fall = ~irq_i & prev_q;
    if (!trig_i)     hit = 1'b0;
    else if (dual_i) hit = rise | fall;
    else             hit = pol_i ? rise : fall;
    // hardware edge dominates a simultaneous software clear
    edge_en = hit | inj_set_i | inj_clr_i;
    edge_d  = hit | inj_set_i | (edge_q & ~inj_clr_i);
    pend_o  = trig_i ? edge_q : ~(irq_i ^ pol_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= irq_i;
      if (edge_en) edge_q <= edge_d;
    end
  end

  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q && !inj_clr_i |=> edge_q);
  p_rise_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && !dual_i && pol_i && irq_i && !prev_q |=> edge_q);
  p_dual_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && dual_i && !irq_i && prev_q |=> edge_q);
  p_inj_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inj_set_i |=> edge_q);
  p_inj_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inj_clr_i && !trig_i |=> !edge_q);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  input  logic [NUM_LINES-1:0]          pend_i,
  output logic [NUM_LINES-1:0]          pol_o,
  output logic [NUM_LINES-1:0]          trig_o,
  output logic [NUM_LINES-1:0]          dual_o,
  output logic [NUM_LINES-1:0]          mask_o,
  output route_t [NUM_LINES-1:0]        route_o,
  output logic [NUM_LINES-1:0]          inj_set_o,
  output logic [NUM_LINES-1:0]          inj_clr_o,
  output logic [WORD_W-1:0]             rdata_o
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic we_pol, we_trig, we_dual, we_inj, we_set, we_clr, mask_en;
  logic [NUM_LINES-1:0] wbits, mask_d;
  logic [NUM_LINES-1:0] pol_q, trig_q, dual_q, mask_q;
  logic [IDX_W-1:0]     inj_idx;
  route_t [NUM_LINES-1:0] route_q;

  always_comb begin
    wbits   = wdata_i[NUM_LINES-1:0];
    we_pol  = wr_i && (addr_i == ADDR_W'(OFS_POL));
    we_trig = wr_i && (addr_i == ADDR_W'(OFS_TRIG));
    we_dual = wr_i && (addr_i == ADDR_W'(OFS_DUAL));
    we_inj  = wr_i && (addr_i == ADDR_W'(OFS_INJECT));
    we_set  = wr_i && (addr_i == ADDR_W'(OFS_MASK_SET));
    we_clr  = wr_i && (addr_i == ADDR_W'(OFS_MASK_CLR));
    mask_en = we_set | we_clr;
    mask_d  = (mask_q | (we_set ? wbits : '0)) & ~(we_clr ? wbits : '0);
    inj_idx = wdata_i[IDX_W-1:0];
    for (int i = 0; i < NUM_LINES; i++) begin
      inj_set_o[i] = we_inj && (inj_idx == IDX_W'(i)) &&  wdata_i[CTL_BIT];
      inj_clr_o[i] = we_inj && (inj_idx == IDX_W'(i)) && !wdata_i[CTL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
    end else begin
      if (we_pol)  pol_q  <= wbits;
      if (we_trig) trig_q <= wbits;
      if (we_dual) dual_q <= wbits;
      if (mask_en) mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_route
    logic   we_r;
    route_t route_d;
    always_comb begin
      we_r        = wr_i && (addr_i == ADDR_W'(OFS_ROUTE + g));
      route_d.en  = wdata_i[CTL_BIT];
      route_d.pin = wdata_i[PIN_FLD_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    route_q[g] <= '0;
      else if (we_r) route_q[g] <= route_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_POL):     rdata_o = WORD_W'(pol_q);
      ADDR_W'(OFS_TRIG):    rdata_o = WORD_W'(trig_q);
      ADDR_W'(OFS_DUAL):    rdata_o = WORD_W'(dual_q);
      ADDR_W'(OFS_MASK_RD): rdata_o = WORD_W'(mask_q);
      ADDR_W'(OFS_PEND_RD): rdata_o = WORD_W'(pend_i);
      default: begin
        for (int i = 0; i < NUM_LINES; i++)
          if (addr_i == ADDR_W'(OFS_ROUTE + i))
            rdata_o = {route_q[i].en, {(WORD_W-1-PIN_FLD_W){1'b0}}, route_q[i].pin};
      end
    endcase
  end

  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign dual_o  = dual_q;
  assign mask_o  = mask_q;
  assign route_o = route_q;

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((mask_q & $past(wbits)) == $past(wbits)));
  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((mask_q & $past(wbits)) == '0));
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_set && !we_clr |=> $stable(mask_q));
endmodule

// File: rtl/irqc_router.sv
module irqc_router
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_PINS  = 6,
  parameter int VEC_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   act_i,
  input  route_t [NUM_LINES-1:0] route_i,
  output logic [NUM_PINS-1:0]    pin_o,
  output logic [VEC_W-1:0]       vec_o
);
  logic [NUM_PINS-1:0] pin_d, pin_q;
  logic [VEC_W-1:0]    vec_d, vec_q;

  always_comb begin
    pin_d = '0;
    for (int i = 0; i < NUM_LINES; i++)
      for (int p = 0; p < NUM_PINS; p++)
        if (act_i[i] && route_i[i].en && (route_i[i].pin == PIN_FLD_W'(p)))
          pin_d[p] = 1'b1;
    vec_d = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--)
      if (pin_d[p]) vec_d = VEC_W'(p + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
      vec_q <= '0;
    end else begin
      pin_q <= pin_d;
      vec_q <= vec_d;
    end
  end

  assign pin_o = pin_q;
  assign vec_o = vec_q;

  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q == '0) |-> (vec_q == '0));
  p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q != '0) |-> (vec_q != '0) && (int'(vec_q) <= NUM_PINS));
  p_pin_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q != '0) |-> $past(act_i != '0));
endmodule

// File: rtl/irq_src_conditioner.sv
module irq_src_conditioner
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_PINS  = 6,
  parameter int ADDR_W    = 8,
  parameter int VEC_W     = $clog2(NUM_PINS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_PINS-1:0]  cpu_pin,
  output logic [VEC_W-1:0]     cpu_vec
);
  logic rst_s1_q, rst_s2_q;
  logic [NUM_LINES-1:0] pol, trig, dual, mask, inj_set, inj_clr, pend, active;
  route_t [NUM_LINES-1:0] route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  irqc_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s2_q), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pend_i(pend), .pol_o(pol), .trig_o(trig),
    .dual_o(dual), .mask_o(mask), .route_o(route), .inj_set_o(inj_set),
    .inj_clr_o(inj_clr), .rdata_o(bus_rdata)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irqc_line u_line (
      .clk(clk), .rst_n(rst_s2_q), .irq_i(irq_in[g]), .pol_i(pol[g]),
      .trig_i(trig[g]), .dual_i(dual[g]), .inj_set_i(inj_set[g]),
      .inj_clr_i(inj_clr[g]), .pend_o(pend[g])
    );
  end

  assign active = pend & mask;

  irqc_router #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_router (
    .clk(clk), .rst_n(rst_s2_q), .act_i(active), .route_i(route),
    .pin_o(cpu_pin), .vec_o(cpu_vec)
  );

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (mask == '0) |=> (cpu_pin == '0));
endmodule

// File: tb/test_irq_src_conditioner.sv
module test_irq_src_conditioner;
  localparam int CLK_P = 10;
  localparam int N  = 32;
  localparam int P  = 6;
  localparam int AW = 8;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [N-1:0] irq = '0;
  logic wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [P-1:0] pin;
  logic [VW-1:0] vec;

  always #(CLK_P/2) clk = ~clk;

  irq_src_conditioner #(.NUM_LINES(N), .NUM_PINS(P), .ADDR_W(AW)) i_irq_src_conditioner (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .cpu_pin(pin), .cpu_vec(vec)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  // behavioural reference model
  logic [31:0] m_pol = '0, m_trig = '0, m_dual = '0, m_mask = '0, m_edge = '0, m_prev = '0;
  logic        m_ren [N];
  int          m_rpin [N];
  logic [P-1:0] m_pin = '0;
  int          m_vec = 0;
  bit          m_s1 = 0, m_s2 = 0;

  initial for (int i = 0; i < N; i++) begin m_ren[i] = 0; m_rpin[i] = 0; end

  function automatic logic [31:0] m_pend();
    logic [31:0] r;
    for (int i = 0; i < N; i++)
      r[i] = m_trig[i] ? m_edge[i] : (m_pol[i] ? irq[i] : !irq[i]);
    return r;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a == 0) return m_pol;
    if (a == 1) return m_trig;
    if (a == 2) return m_dual;
    if (a == 6) return m_mask;
    if (a == 7) return m_pend();
    if (a >= 8 && a < 8 + N) return {m_ren[a-8], 25'd0, 6'(m_rpin[a-8])};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
      m_pol = '0; m_trig = '0; m_dual = '0; m_mask = '0; m_edge = '0; m_prev = '0;
      m_pin = '0; m_vec = 0;
      for (int i = 0; i < N; i++) begin m_ren[i] = 0; m_rpin[i] = 0; end
    end else begin
      if (m_s2) begin
        logic [31:0] pd, hit, sset, sclr;
        logic [P-1:0] np;
        int nv;
        pd = m_pend() & m_mask;
        np = '0;
        for (int i = 0; i < N; i++)
          if (pd[i] && m_ren[i] && m_rpin[i] < P) np[m_rpin[i]] = 1'b1;
        nv = 0;
        for (int p = P - 1; p >= 0; p--) if (np[p]) nv = p + 1;
        for (int i = 0; i < N; i++) begin
          bit r, f;
          r = irq[i] && !m_prev[i];
          f = !irq[i] && m_prev[i];
          hit[i] = m_trig[i] && (m_dual[i] ? (r || f) : (m_pol[i] ? r : f));
        end
        sset = '0; sclr = '0;
        if (wr && addr == 3) begin
          if (wdata[31]) sset[wdata[4:0]] = 1'b1;
          else           sclr[wdata[4:0]] = 1'b1;
        end
        m_edge = (m_edge & ~sclr) | sset | hit;
        if (wr) begin
          case (int'(addr))
            0: m_pol = wdata;
            1: m_trig = wdata;
            2: m_dual = wdata;
            4: m_mask = m_mask & ~wdata;
            5: m_mask = m_mask | wdata;
            default: if (addr >= 8 && addr < 8 + N) begin
              m_ren[addr-8]  = wdata[31];
              m_rpin[addr-8] = int'(wdata[5:0]);
            end
          endcase
        end
        m_prev = irq;
        m_pin = np;
        m_vec = nv;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R7 pins", 32'(pin), 32'(m_pin));
      chk("R8 vector", 32'(vec), 32'(m_vec));
      chk("R2 read data", rdata, m_read(int'(addr)));
    end
  end

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk); #1;
    wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic set_irq(logic [31:0] v);
    @(negedge clk); #1 irq = v;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk); #1 addr = AW'(a);
    #2 chk(tag, rdata, exp);
  endtask

  task automatic pin_chk(logic [P-1:0] ep, int ev, string tag);
    repeat (2) @(negedge clk);
    #1 chk(tag, 32'(pin), 32'(ep));
    chk(tag, 32'(vec), 32'(ev));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    #1 cmp_on = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(6, 32'h0, "R1 mask after reset");
    rd_chk(0, 32'h0, "R1 polarity after reset");
    rd_chk(8, 32'h0, "R1 routing after reset");
    #1 chk("R1 pins after reset", 32'(pin), 32'h0);
    chk("R1 vector after reset", 32'(vec), 32'h0);

    // R2 level sense
    rd_chk(7, 32'hFFFF_FFFF, "R2 active-low lines idle low");
    wr_reg(0, 32'hFFFF_FFFF);
    rd_chk(7, 32'h0, "R2 active-high lines idle low");
    set_irq(32'h1);
    rd_chk(7, 32'h1, "R2 line0 high pending");

    // R7/R8 routing line0 to pin 2
    wr_reg(8, 32'h8000_0002);
    wr_reg(5, 32'h1);
    pin_chk(6'b000100, 3, "R7 R8 line0 on pin2");

    // R3 single edge
    set_irq(32'h5);
    wr_reg(0, 32'hFFFF_FFFB);
    wr_reg(1, 32'h6);
    rd_chk(7, 32'h1, "R3 edge lines idle");
    set_irq(32'h7);
    rd_chk(7, 32'h3, "R3 rising latch");
    set_irq(32'h5);
    rd_chk(7, 32'h3, "R3 latch held after fall");
    set_irq(32'h1);
    rd_chk(7, 32'h7, "R3 falling latch with polarity 0");

    // R5 injection
    wr_reg(3, 32'h0000_0001);
    rd_chk(7, 32'h5, "R5 clear line1");
    wr_reg(3, 32'h0000_0002);
    rd_chk(7, 32'h1, "R5 clear line2");
    wr_reg(3, 32'h8000_0001);
    rd_chk(7, 32'h3, "R5 set line1");
    wr_reg(3, 32'h8000_0102);
    rd_chk(7, 32'h7, "R5 middle bits ignored");
    wr_reg(3, 32'h1);
    wr_reg(3, 32'h2);
    rd_chk(7, 32'h1, "R5 cleared again");

    // R4 dual edge on line3
    wr_reg(1, 32'hE);
    wr_reg(2, 32'h8);
    set_irq(32'h9);
    rd_chk(7, 32'h9, "R4 dual rising");
    wr_reg(3, 32'h3);
    rd_chk(7, 32'h1, "R4 cleared");
    set_irq(32'h1);
    rd_chk(7, 32'h9, "R4 dual falling");
    wr_reg(3, 32'h3);

    // R6 mask set/clear
    wr_reg(5, 32'hF0);
    rd_chk(6, 32'hF1, "R6 set bits");
    wr_reg(4, 32'h30);
    rd_chk(6, 32'hC1, "R6 clear bits");
    wr_reg(4, 32'h0);
    rd_chk(6, 32'hC1, "R6 zero clear word");
    wr_reg(5, 32'h0);
    rd_chk(6, 32'hC1, "R6 zero set word");

    // R9 read-only words
    wr_reg(6, 32'hFFFF_FFFF);
    rd_chk(6, 32'hC1, "R9 mask word read-only");
    wr_reg(7, 32'hFFFF_FFFF);
    rd_chk(7, 32'h1, "R9 pending word read-only");

    // R8 lowest pin wins
    wr_reg(9, 32'h8000_0000);
    wr_reg(5, 32'h2);
    wr_reg(3, 32'h8000_0001);
    pin_chk(6'b000101, 1, "R8 lowest pin");

    // R10 hardware edge beats software clear
    wr_reg(3, 32'h1);
    @(negedge clk); #1;
    irq = 32'h3; wr = 1'b1; addr = AW'(3); wdata = 32'h1;
    @(negedge clk); #1 wr = 1'b0;
    rd_chk(7, 32'h3, "R10 edge wins over clear");

    // R11 unreachable pins
    wr_reg(9, 32'h8000_0007);
    pin_chk(6'b000100, 3, "R11 pin out of range");
    wr_reg(9, 32'h0000_0000);
    pin_chk(6'b000100, 3, "R11 routing disabled");
    rd_chk(8, 32'h8000_0002, "R7 routing readback");

    // mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); #1;
      if ($urandom_range(3) == 0) irq = $urandom;
      else irq[$urandom_range(N-1)] = $urandom_range(1);
      wr = ($urandom_range(3) == 0);
      addr = AW'($urandom_range(8 + N + 1));
      wdata = $urandom;
    end
    @(negedge clk); #1 wr = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule